// File: doc/BRIEF.md
# IQ Demodulator with Offset Cancellation

This block turns a stream of ADC samples of an intermediate-frequency signal into I/Q pairs. The ADC clock runs at four times the IF. For that reason, consecutive samples land on the in-phase axis, the quadrature axis, the negative in-phase axis and the negative quadrature axis, and the pattern then repeats. A two-bit phase sequencer plays the part of the divide-by-2 and divide-by-4 clocks. Its low bit steers each sample to the I or Q path. Its high bit marks the sample as sign-inverted.

Each path keeps the previous sample it accepted. Each path forms half of the difference between its positive-phase and negative-phase samples. Any constant ADC offset appears equally in both samples and cancels. Because every new sample pairs with the one before it, results arrive at the full pair rate, which is half the ADC rate. A strobe marks each completed I/Q pair.

A synchronisation pulse resets the sequencer and the sample history. Every demodulator that shares the pulse then uses the same demux timing.

Top module: `iq_offset_demod`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `i_out` and `q_out` are 0 until the first result is produced.
- R2: Accepted samples are interpreted in a fixed repeating order using a 2-bit phase. Phase 0 is +I, phase 1 is +Q, phase 2 is −I and phase 3 is −Q. Bit 0 of the phase selects the path (0 = I, 1 = Q), and bit 1 marks the inverted sample. The phase advances by one every clock cycle that carries no sync.
- R3: On each I-path sample after the first since reset or sync, the I result is floor((P − N) / 2). P is the latest phase-0 sample and N is the latest phase-2 sample, both taken as two's-complement integers. The difference is formed one bit wider than the input so that it never overflows. Full-scale inputs (P = 2047, N = −2048 at 12 bits) give 2047.
- R4: The Q result follows the same rule as R3, with phase-1 samples as P and phase-3 samples as N. P = −2048 with N = 2047 gives −2048.
- R5: Adding the same constant offset to every sample leaves `i_out` and `q_out` unchanged. The samples off + x and off − x yield exactly x.
- R6: `out_valid` is high for exactly one cycle, in the cycle after each Q-path sample that completes a pair. `i_out` and `q_out` hold the newest I and Q results in that cycle. In steady operation the strobe comes every second cycle.
- R7: After reset or sync, the first `out_valid` appears in the cycle after the fourth accepted sample (−Q). It carries I = floor((s1 − s3) / 2) and Q = floor((s2 − s4) / 2), where s1 to s4 are the accepted samples in order.
- R8: A sample presented in the same cycle as `sync` is discarded. The next sample is taken as phase 0 (+I).
- R9: A sync arriving mid-stream clears the history of both paths. No `out_valid` follows until four new samples have been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ADC sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Phase realignment pulse; the sample in this cycle is dropped |
| adc_sample | input | W | Signed ADC sample, one per clock |
| i_out | output | W | Signed offset-corrected in-phase result |
| q_out | output | W | Signed offset-corrected quadrature result |
| out_valid | output | 1 | One-cycle strobe for a completed I/Q pair |

## Verification
The properties assume that `sync` and `adc_sample` are synchronous to `clk` and are driven away from its rising edge. They also assume that one sample arrives every cycle, so the phase advances freely between sync pulses. `sync` may be a single-cycle pulse or may be held or repeated. The stimulus keeps to this by driving on the falling edge. It mixes fully random samples and occasional random sync pulses, some of them back-to-back, with directed offset, full-scale and realignment sequences. All samples stay inside the signed input range.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  // Phase encoding: bit 0 selects the path, bit 1 marks the inverted sample.
  typedef enum logic [1:0] {
    PH_I_POS = 2'd0,
    PH_Q_POS = 2'd1,
    PH_I_NEG = 2'd2,
    PH_Q_NEG = 2'd3
  } iqd_phase_e;

  localparam int unsigned NUM_PATHS = 2;
endpackage

// File: rtl/iqd_phase_seq.sv
module iqd_phase_seq
  import iqd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync,
  output iqd_phase_e phase
);
  logic [1:0] phase_inc;
  assign phase_inc = phase + 2'd1;

  // R2: free-running quarter-cycle counter; R8: sync forces +I next cycle
  always_ff @(posedge clk) begin
    if (!rst_n)     phase <= PH_I_POS;
    else if (sync)  phase <= PH_I_POS;
    else            phase <= iqd_phase_e'(phase_inc);
  end
endmodule

// File: rtl/iqd_path.sv
module iqd_path #(
  parameter int unsigned W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                take,
  input  logic                neg,
  input  logic signed [W-1:0] sample,
  output logic signed [W-1:0] result,
  output logic                primed,
  output logic                fresh
);
  // R3/R4: one extra bit for the difference, then floor divide by two
  function automatic logic signed [W-1:0] half_diff(
    input logic signed [W-1:0] pos_s,
    input logic signed [W-1:0] neg_s
  );
    logic signed [W:0] d;
    d = {pos_s[W-1], pos_s} - {neg_s[W-1], neg_s};
    return d[W:1];
  endfunction

  logic signed [W-1:0] prev;
  logic                have_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev      <= '0;
      have_prev <= 1'b0;
      result    <= '0;
      primed    <= 1'b0;
      fresh     <= 1'b0;
    end else begin
      fresh <= 1'b0;
      if (restart) begin
        have_prev <= 1'b0;
        primed    <= 1'b0;
      end else if (take) begin
        prev      <= sample;
        have_prev <= 1'b1;
        primed    <= have_prev;
        fresh     <= have_prev;
        if (have_prev)
          result <= neg ? half_diff(prev, sample) : half_diff(sample, prev);
      end
    end
  end
endmodule

// File: rtl/iq_offset_demod.sv
module iq_offset_demod
  import iqd_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync,
  input  logic signed [W-1:0] adc_sample,
  output logic signed [W-1:0] i_out,
  output logic signed [W-1:0] q_out,
  output logic                out_valid
);
  iqd_phase_e          phase_w;
  logic [NUM_PATHS-1:0] take_w;
  logic [NUM_PATHS-1:0] primed_w;
  logic [NUM_PATHS-1:0] fresh_w;
  logic signed [W-1:0]  res_w [NUM_PATHS];
  logic                 q_take;

  iqd_phase_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .sync  (sync),
    .phase (phase_w)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    assign take_w[p] = !sync && (phase_w[0] == p[0]);
    iqd_path #(.W(W)) u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (sync),
      .take    (take_w[p]),
      .neg     (phase_w[1]),
      .sample  (adc_sample),
      .result  (res_w[p]),
      .primed  (primed_w[p]),
      .fresh   (fresh_w[p])
    );
  end

  assign q_take    = take_w[1];
  assign i_out     = res_w[0];
  assign q_out     = res_w[1];
  // R6: a pair is complete when the Q path has just produced a result
  assign out_valid = fresh_w[1] && primed_w[0];
endmodule

// File: rtl/iqd_checks.sv
module iqd_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       sync,
  input logic [1:0] phase,
  input logic       take_q,
  input logic       out_valid
);
  // R2: phase steps by one when no sync is present
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> phase == $past(phase) + 2'd1);

  // R8: sync realigns to +I on the following cycle
  a_r8_sync_to_ipos: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> phase == 2'd0);

  // R6: strobe lasts a single cycle
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: strobe only follows an accepted Q-path sample
  a_r6_after_q: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(take_q));

  // R9: no strobe right after a sync
  a_r9_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !out_valid);
endmodule

bind iq_offset_demod iqd_checks u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync      (sync),
  .phase     (phase_w),
  .take_q    (q_take),
  .out_valid (out_valid)
);

// File: tb/tb_iq_offset_demod.sv
module tb_iq_offset_demod;
  localparam int W = 12;
  localparam int MAXV = (1 << (W-1)) - 1;
  localparam int MINV = -(1 << (W-1));

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                sync = 1'b0;
  logic signed [W-1:0] adc_sample = '0;
  logic signed [W-1:0] i_out, q_out;
  logic                out_valid;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  int m_ph = 0;
  int m_prev [2];
  bit m_have [2];
  bit m_prim [2];
  int m_res  [2];
  bit exp_valid = 0;
  int exp_i = 0, exp_q = 0;

  iq_offset_demod #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .adc_sample(adc_sample),
    .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
  );

  always #10 clk = ~clk;

  function automatic int hd_ref(int p, int n);
    int d;
    d = p - n;
    if (d >= 0) return d / 2;
    return -((1 - d) / 2);
  endfunction

  task automatic chk(string t, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic model(bit s, int a);
    if (s) begin
      m_ph = 0;
      m_have[0] = 0; m_have[1] = 0;
      m_prim[0] = 0; m_prim[1] = 0;
      exp_valid = 0;
    end else begin
      int p = m_ph & 1;
      bit ng = (m_ph >> 1) != 0;
      bit v = (p == 1) && m_have[1] && m_prim[0];
      if (m_have[p]) m_res[p] = ng ? hd_ref(m_prev[p], a) : hd_ref(a, m_prev[p]);
      m_prim[p] = m_have[p];
      m_have[p] = 1;
      m_prev[p] = a;
      exp_valid = v;
      if (v) begin exp_i = m_res[0]; exp_q = m_res[1]; end
      m_ph = (m_ph + 1) % 4;
    end
  endtask

  task automatic compare();
    chk(tag, int'(out_valid), int'(exp_valid), "out_valid");
    if (exp_valid && out_valid) begin
      chk(tag, int'(i_out), exp_i, "i_out");
      chk(tag, int'(q_out), exp_q, "q_out");
    end
  endtask

  task automatic step(bit s, int a);
    @(negedge clk);
    compare();
    sync = s;
    adc_sample = a[W-1:0];
    model(s, a);
  endtask

  function automatic int rnd_sample();
    return int'($urandom_range(0, (1 << W) - 1)) + MINV;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    m_prev[0] = 0; m_prev[1] = 0; m_have[0] = 0; m_have[1] = 0;
    m_prim[0] = 0; m_prim[1] = 0; m_res[0] = 0; m_res[1] = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", int'(out_valid), 0, "out_valid in reset");
    chk("R1", int'(i_out), 0, "i_out in reset");
    chk("R1", int'(q_out), 0, "q_out in reset");
    rst_n = 1'b1;
    sync = 1'b1;
    adc_sample = 12'sd999;
    model(1, 999);

    // R8 and R7: sync-cycle sample dropped, first strobe after four samples
    tag = "R8";
    step(0, 100); step(0, 50); step(0, -60);
    tag = "R7";
    step(0, -10);
    @(negedge clk);
    chk("R7", int'(out_valid), 1, "first strobe");
    chk("R7", int'(i_out), 80, "first i_out");
    chk("R7", int'(q_out), 30, "first q_out");
    compare();
    sync = 1'b0; adc_sample = 12'sd5; model(0, 5);

    // R3 and R4: full scale, after realignment
    tag = "R3";
    step(1, 0);
    for (int k = 0; k < 4; k++) begin
      step(0, MAXV); step(0, MINV); tag = "R4"; step(0, MINV); step(0, MAXV);
    end
    @(negedge clk);
    chk("R3", int'(i_out), 2047, "full-scale i_out");
    chk("R4", int'(q_out), -2048, "full-scale q_out");
    compare();
    sync = 1'b0; adc_sample = '0; model(0, 0);

    // R5: offset cancellation
    tag = "R5";
    step(1, 0);
    for (int k = 0; k < 40; k++) begin
      int off = int'($urandom_range(0, 2000)) - 1000;
      int xi  = int'($urandom_range(0, 1800)) - 900;
      int xq  = int'($urandom_range(0, 1800)) - 900;
      step(0, off + xi); step(0, off + xq); step(0, off - xi); step(0, off - xq);
      @(negedge clk);
      if (k > 0) begin
        chk("R5", int'(out_valid), 1, "strobe");
        chk("R5", int'(q_out), xq, "q_out offset-free");
      end
      compare();
      sync = 1'b0; adc_sample = '0; model(0, 0);
      step(1, 0);
    end

    // R6 and R9: random stream with occasional sync, some back-to-back
    tag = "R6";
    for (int k = 0; k < 3000; k++) begin
      bit s = ($urandom_range(0, 39) == 0);
      if (s) tag = "R9"; else if ((k % 50) == 0) tag = "R6";
      step(s, rnd_sample());
    end
    tag = "R2";
    for (int k = 0; k < 400; k++) step((k % 97) == 3 || (k % 97) == 4, rnd_sample());
    step(0, 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule